// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Access Protection

This block caches recent virtual-to-physical page translations for a 4 KB page size. A lookup presents a full virtual address together with the kind of access (read, write or instruction fetch). The upper bits form the virtual page number, and it is compared against every valid entry in parallel. One clock later the block reports one of three outcomes. A hit returns the physical address. A miss means no usable translation is held. A protection fault means a translation exists but its permission bits forbid the requested access.

After a miss, an external table walker supplies a page number / physical page / permission triple on the refill port and the requester retries. Only a requester in supervisor mode may install entries. A refill attempted in user mode changes nothing and is answered with a fault pulse. The refill slot is chosen in this order: an entry already holding the same virtual page, then the lowest-numbered invalid entry, then a round-robin victim. A flush input invalidates the whole array in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, `rsp_paddr` equals the stored physical page number concatenated with the low 12 bits of the looked-up virtual address, which pass through unchanged. It appears in the cycle after the lookup is presented.
- R2: Out of reset every entry is invalid and all outputs are 0. A lookup whose page matches no valid entry gives `rsp_miss`=1, `rsp_hit`=0 and `rsp_paddr`=0.
- R3: `lk_acc` encodes 0=read, 1=write, 2=execute. Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. A matching lookup whose access bit is clear gives `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0.
- R4: In the cycle after a lookup, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is 1. In the cycle after a cycle with no lookup, all three are 0.
- R5: A refill with `sup_mode`=1 installs its entry at the clock edge, so a lookup in the next cycle can hit it.
- R6: A refill with `sup_mode`=0 leaves the array unchanged and pulses `rf_fault` for one cycle, in the next cycle.
- R7: A refill whose page number is already held overwrites that entry in place. No duplicate is created and no other entry is evicted.
- R8: A refill of a new page fills the lowest-numbered invalid entry. When all entries are valid, it replaces the entry at a round-robin pointer. The pointer starts at 0, advances by one after each such replacement, and wraps.
- R9: `flush` invalidates all entries in one cycle and returns the round-robin pointer to 0. A refill in the same cycle as a flush is discarded.
- R10: A lookup in the same cycle as a refill sees the array as it was before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| sup_mode | input | 1 | 1 when the requester is in supervisor mode |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | VPN_W | Virtual page number to install |
| rf_ppn | input | PPN_W | Physical page number to install |
| rf_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| rsp_hit | output | 1 | Translation granted |
| rsp_miss | output | 1 | No valid translation held |
| rsp_fault | output | 1 | Translation held but access not permitted |
| rsp_paddr | output | PPN_W+OFF_W | Physical address on a hit, else 0 |
| rf_fault | output | 1 | User-mode refill rejected |

## Verification
The bench builds the block with ENTRIES=8 and the default 20-bit page numbers. With that size the array fills after eight refills, so the change from filling invalid slots to round-robin replacement is reached in a few cycles. So are in-place overwrites of a full array and successive evictions. Lookups are issued under every access kind against entries with different permission sets, including lookups that coincide with a refill and lookups that follow a flush that dropped a refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2
  } acc_e;

  typedef struct packed {
    logic ex;
    logic wr;
    logic rd;
  } perm_t;
endpackage

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  logic [1:0] acc,
  input  perm_t      perm,
  output logic       allow
);
  always_comb begin
    case (acc)
      ACC_RD:  allow = perm.rd;
      ACC_WR:  allow = perm.wr;
      ACC_EX:  allow = perm.ex;
      default: allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  perm_t              wr_perm,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_any,
  output logic [PPN_W-1:0]   lk_ppn,
  output perm_t              lk_perm,
  output logic [ENTRIES-1:0] rf_match,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [VPN_W-1:0] tag_q    [ENTRIES];
  logic [PPN_W-1:0] ppn_mem  [ENTRIES];
  perm_t            perm_mem [ENTRIES];
  logic [ENTRIES-1:0] lk_match;

  // valid bits: reset and flushed as a whole
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_vec <= '0;
    end else if (wr_en) begin
      valid_vec[wr_idx] <= 1'b1;
    end
  end

  // payload storage, written like a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx]    <= wr_vpn;
      ppn_mem[wr_idx]  <= wr_ppn;
      perm_mem[wr_idx] <= wr_perm;
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign lk_match[g] = valid_vec[g] && (tag_q[g] == lk_vpn);
      assign rf_match[g] = valid_vec[g] && (tag_q[g] == wr_vpn);
    end
  endgenerate

  // matches are one-hot (no duplicates), so an OR-select is exact
  always_comb begin
    lk_ppn  = '0;
    lk_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_ppn  = lk_ppn  | (ppn_mem[i] & {PPN_W{lk_match[i]}});
      lk_perm = lk_perm | (perm_mem[i] & {3{lk_match[i]}});
    end
  end

  assign lk_any = |lk_match;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [ENTRIES-1:0] rf_match,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   tgt_idx
);
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] match_idx;
  logic [IDX_W-1:0] free_idx;
  logic             has_free;
  logic             evict;

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rf_match[i]) match_idx = IDX_W'(i);
    end
  end

  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        has_free = 1'b1;
      end
    end
  end

  assign evict   = !(|rf_match) && !has_free;
  assign tgt_idx = (|rf_match) ? match_idx : (has_free ? free_idx : rr_ptr);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rr_ptr <= '0;
    end else if (wr_en && evict) begin
      if (rr_ptr == IDX_W'(ENTRIES - 1)) rr_ptr <= '0;
      else                               rr_ptr <= rr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             sup_mode,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_acc,
  input  logic             rf_valid,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic [2:0]       rf_perm,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rf_fault
);
  logic               wr_en;
  logic [IDX_W-1:0]   tgt_idx;
  logic               lk_any;
  logic [PPN_W-1:0]   lk_ppn;
  perm_t              lk_perm;
  logic [ENTRIES-1:0] rf_match;
  logic [ENTRIES-1:0] valid_vec;
  logic               allow;

  assign wr_en = rf_valid && sup_mode && !flush;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) cam_i (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(wr_en), .wr_idx(tgt_idx), .wr_vpn(rf_vpn), .wr_ppn(rf_ppn),
    .wr_perm(perm_t'(rf_perm)),
    .lk_vpn(lk_vaddr[VA_W-1:OFF_W]),
    .lk_any(lk_any), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
    .rf_match(rf_match), .valid_vec(valid_vec)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) vic_i (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en),
    .rf_match(rf_match), .valid_vec(valid_vec), .tgt_idx(tgt_idx)
  );

  tlb_perm perm_i (.acc(lk_acc), .perm(lk_perm), .allow(allow));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rf_fault  <= 1'b0;
    end else begin
      rsp_hit   <= lk_valid && lk_any && allow;
      rsp_miss  <= lk_valid && !lk_any;
      rsp_fault <= lk_valid && lk_any && !allow;
      rsp_paddr <= (lk_valid && lk_any && allow) ? {lk_ppn, lk_vaddr[OFF_W-1:0]} : '0;
      rf_fault  <= rf_valid && !sup_mode;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            sup_mode,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            rf_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rf_fault
);
  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]));

  // R3
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault || rsp_miss) |-> rsp_paddr == '0);

  // R4
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lk_valid)) |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(lk_valid) |-> !(rsp_hit || rsp_miss || rsp_fault));

  // R6
  user_refill_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_valid && !sup_mode) |=> rf_fault);

  // R6
  sup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(rf_valid && !sup_mode) |=> !rf_fault);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (flush ##1 lk_valid) |=> rsp_miss);
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) chk_i (.*);

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;
  localparam int ENT   = 8;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int OFF_W = 12;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, sup_mode = 1'b0, lk_valid = 1'b0, rf_valid = 1'b0;
  logic [VA_W-1:0]  lk_vaddr = '0;
  logic [1:0]       lk_acc = '0;
  logic [VPN_W-1:0] rf_vpn = '0;
  logic [PPN_W-1:0] rf_ppn = '0;
  logic [2:0]       rf_perm = '0;
  logic rsp_hit, rsp_miss, rsp_fault, rf_fault;
  logic [PA_W-1:0] rsp_paddr;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic            hit;
    logic            miss;
    logic            fault;
    logic [PA_W-1:0] paddr;
    string           tag;
  } exp_t;
  exp_t exp_q[$];
  logic issued = 1'b0;

  always #4 clk = ~clk;

  tlb_xlate #(.ENTRIES(ENT), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rst(rst), .flush(flush), .sup_mode(sup_mode),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_perm(rf_perm),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .rf_fault(rf_fault)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // monitor: bench-side delay flag marks the cycle a response is due
  always @(posedge clk) issued <= lk_valid && !rst;

  always @(negedge clk) begin
    if (issued) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "response", "none queued");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_hit == e.hit && rsp_miss == e.miss && rsp_fault == e.fault
              && rsp_paddr == e.paddr, e.tag,
              $sformatf("h%0b m%0b f%0b pa=%h", rsp_hit, rsp_miss, rsp_fault, rsp_paddr),
              $sformatf("h%0b m%0b f%0b pa=%h", e.hit, e.miss, e.fault, e.paddr));
      end
    end
  end

  // one cycle of stimulus; lookup and refill may coincide
  task automatic drive(input bit lk, input logic [VPN_W-1:0] lvpn, input logic [OFF_W-1:0] off,
                       input logic [1:0] acc, input bit rf, input bit sup,
                       input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                       input logic [2:0] perm, input bit fl,
                       input bit eh, input bit em, input bit ef,
                       input logic [PPN_W-1:0] eppn, input string tag);
    exp_t e;
    @(negedge clk);
    lk_valid = lk; lk_vaddr = {lvpn, off}; lk_acc = acc;
    rf_valid = rf; sup_mode = sup; rf_vpn = vpn; rf_ppn = ppn; rf_perm = perm;
    flush = fl;
    if (lk) begin
      e.hit = eh; e.miss = em; e.fault = ef;
      e.paddr = eh ? {eppn, off} : '0;
      e.tag = tag;
      exp_q.push_back(e);
    end
    @(negedge clk);
    lk_valid = 1'b0; rf_valid = 1'b0; flush = 1'b0;
    if (rf) check(rf_fault == !sup, (sup ? "R5" : "R6"),
                  $sformatf("rf_fault=%0b", rf_fault), $sformatf("%0b", !sup));
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] off,
                      input logic [1:0] acc, input bit eh, input bit em, input bit ef,
                      input logic [PPN_W-1:0] eppn, input string tag);
    drive(1'b1, v, off, acc, 1'b0, 1'b0, '0, '0, '0, 1'b0, eh, em, ef, eppn, tag);
  endtask

  task automatic fill(input bit sup, input logic [VPN_W-1:0] v,
                      input logic [PPN_W-1:0] p, input logic [2:0] perm);
    drive(1'b0, '0, '0, 2'd0, 1'b1, sup, v, p, perm, 1'b0, 1'b0, 1'b0, 1'b0, '0, "");
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    check(!rsp_hit && !rsp_miss && !rsp_fault && rsp_paddr == '0 && !rf_fault, "R2",
          "outputs nonzero", "all zero");
    look(20'h00005, 12'h123, 2'd0, 0, 1, 0, '0, "R2 empty miss");
    // R6 user refill rejected, nothing installed
    fill(1'b0, 20'h00005, 20'hABCDE, 3'b111);
    look(20'h00005, 12'h123, 2'd0, 0, 1, 0, '0, "R6 user refill ignored");
    // R5 / R1 / R3
    fill(1'b1, 20'h00005, 20'hABCDE, 3'b011);
    look(20'h00005, 12'h123, 2'd0, 1, 0, 0, 20'hABCDE, "R1 R5 read hit");
    look(20'h00005, 12'hFFF, 2'd1, 1, 0, 0, 20'hABCDE, "R1 write hit");
    look(20'h00005, 12'h000, 2'd2, 0, 0, 1, '0, "R3 exec denied");
    fill(1'b1, 20'h00006, 20'h0F0F0, 3'b100);
    look(20'h00006, 12'h010, 2'd0, 0, 0, 1, '0, "R3 read denied");
    look(20'h00006, 12'h010, 2'd2, 1, 0, 0, 20'h0F0F0, "R3 exec allowed");
    look(20'h00006, 12'h010, 2'd1, 0, 0, 1, '0, "R3 write denied");
    // fill the rest of the array: entries 2..7
    for (int i = 0; i < ENT - 2; i++) fill(1'b1, 20'(7 + i), 20'(32'h200 + i), 3'b111);
    // R7 overwrite held page in place
    fill(1'b1, 20'h00005, 20'h11111, 3'b111);
    look(20'h00005, 12'h444, 2'd2, 1, 0, 0, 20'h11111, "R7 overwrite");
    look(20'h00006, 12'h001, 2'd2, 1, 0, 0, 20'h0F0F0, "R7 no eviction");
    for (int i = 0; i < ENT - 2; i++)
      look(20'(7 + i), 12'h008, 2'd1, 1, 0, 0, 20'(32'h200 + i), "R7 no eviction");
    // R8 round robin from entry 0
    fill(1'b1, 20'h00040, 20'h00400, 3'b001);
    look(20'h00005, 12'h0, 2'd0, 0, 1, 0, '0, "R8 victim entry0");
    look(20'h00006, 12'h0, 2'd2, 1, 0, 0, 20'h0F0F0, "R8 entry1 kept");
    look(20'h00040, 12'h0AB, 2'd0, 1, 0, 0, 20'h00400, "R8 new page");
    fill(1'b1, 20'h00041, 20'h00410, 3'b001);
    look(20'h00006, 12'h0, 2'd2, 0, 1, 0, '0, "R8 victim entry1");
    look(20'h00007, 12'h0, 2'd0, 1, 0, 0, 20'h00200, "R8 entry2 kept");
    // R10 concurrent lookup sees old contents
    drive(1'b1, 20'h00042, 12'h777, 2'd0, 1'b1, 1'b1, 20'h00042, 20'h00420, 3'b001, 1'b0,
          0, 1, 0, '0, "R10 concurrent miss");
    look(20'h00042, 12'h777, 2'd0, 1, 0, 0, 20'h00420, "R10 later hit");
    look(20'h00007, 12'h0, 2'd0, 0, 1, 0, '0, "R8 victim entry2");
    // R9 flush with simultaneous refill
    drive(1'b0, '0, '0, 2'd0, 1'b1, 1'b1, 20'h00050, 20'h00500, 3'b111, 1'b1,
          0, 0, 0, '0, "");
    look(20'h00040, 12'h0, 2'd0, 0, 1, 0, '0, "R9 flushed");
    look(20'h00050, 12'h0, 2'd0, 0, 1, 0, '0, "R9 refill dropped");
    fill(1'b1, 20'h00060, 20'h00600, 3'b010);
    look(20'h00060, 12'h321, 2'd1, 1, 0, 0, 20'h00600, "R9 refill after flush");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4", $sformatf("%0d pending", exp_q.size()), "0 pending");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule